// File: doc/BRIEF.md
# Interrupt Acknowledge and Priority Stack Unit

This unit sits between an interrupt arbiter and one processor. The arbiter hands it the vector number and priority of the request that currently wins. The unit keeps the vector in an acknowledge word, next to a software-programmed vector-table base. Software reads that word to learn which handler to run. Each acknowledge raises the processor's current priority to the level of the acknowledged request. The priority it replaces is saved on a small last-in first-out stack.

When a handler finishes, software writes the end-of-interrupt location. The unit then restores the most recently saved priority. Two mode inputs change this behaviour:
- **Hardware vector mode.** The priority raise happens on a dedicated acknowledge handshake instead of a register read, and end-of-interrupt writes leave the stack alone.
- **Entry-size mode.** This selects wider vector-table entries. The vector moves up one bit and the base loses its lowest bit.

The current priority is an output, so the arbiter can mask requests at or below it.

Top module: `intack_unit`

## Requirements
- R1: After reset, the table base, the stored vector, the current priority and the stack depth are all zero. A read of the acknowledge word returns 0 and `cur_pri` is 0.
- R2: The stored vector and the pending priority are loaded from `req_vec`/`req_pri` on every clock edge where `req_valid` is high, in either vector mode. When `req_valid` is low they hold their values.
- R3: With `wide_entry`=0, a read at offset 0x14 returns `{base[20:0], vec[8:0], 2'b00}` (base in bits 31:11, vector in bits 10:2). A write at 0x14 loads the base from `bus_wdata[31:11]`.
- R4: With `wide_entry`=1, the same read returns `{base[20:1], vec[8:0], 3'b000}`. The vector sits in bits 11:3 and bits 2:0 read as 0.
- R5: With `hw_mode`=0, a read at 0x14 pushes `cur_pri` onto the stack. It also loads the pending priority into `cur_pri`, which is visible after that clock edge.
- R6: With `hw_mode`=1, a read at 0x14 leaves `cur_pri` and the stack unchanged, and a pulse on `hw_ack` performs the push and load instead. With `hw_mode`=0, `hw_ack` has no effect.
- R7: With `hw_mode`=0, any write at 0x18 pops the most recently pushed priority into `cur_pri`. The write data has no effect on this.
- R8: With `hw_mode`=1, a write at 0x18 leaves `cur_pri` and the stack unchanged.
- R9: A read at 0x18, or at any offset other than 0x14, returns 0.
- R10: The stack holds 15 priorities. A push onto a full stack discards the oldest entry, and pops return the saved values newest first.
- R11: A pop from an empty stack loads priority 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt request to the processor is asserted |
| req_vec | input | 9 | Vector of the winning request |
| req_pri | input | 4 | Priority of the winning request |
| hw_mode | input | 1 | 1 = hardware vector mode |
| wide_entry | input | 1 | 1 = wide vector-table entries |
| hw_ack | input | 1 | Hardware acknowledge handshake pulse |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| cur_pri | output | 4 | Current processor priority |

## Verification
The acknowledge word is tried with an all-zero base, an all-ones base and vector, and mixed checkerboard values, each in both entry sizes. This separates a misplaced vector from a base bit wrongly kept in wide mode. Priority sequencing is driven in both vector modes. Reads, hardware pulses and end-of-interrupt writes with zero and all-ones data are applied in each mode, to show which event moves the priority. The stack is filled past its depth with values that differ from 0, so the 16th pop tells a dropped oldest entry apart from an empty-stack 0.

// File: rtl/intack_pkg.sv
package intack_pkg;
    localparam int WORD_W   = 32;
    localparam int BASE_W   = 21;
    localparam int VEC_W    = 9;
    localparam int PRI_W    = 4;
    localparam int DEPTH    = 15;
    localparam int ADDR_W   = 8;
    localparam logic [ADDR_W-1:0] ACK_OFS = 8'h14;
    localparam logic [ADDR_W-1:0] EOI_OFS = 8'h18;

    typedef logic [PRI_W-1:0] pri_t;
endpackage

// File: rtl/priority_lifo.sv
module priority_lifo #(
    parameter int DEPTH = 15,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top_val
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stk;
        logic [CW-1:0]           cnt;
    } lifo_t;

    lifo_t d, q;

    always_comb begin
        d = q;
        if (push) begin
            for (int i = DEPTH - 1; i > 0; i--) begin
                d.stk[i] = q.stk[i-1];
            end
            d.stk[0] = push_val;
            if (q.cnt != CW'(DEPTH)) begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                d.stk[i] = q.stk[i+1];
            end
            d.stk[DEPTH-1] = '0;
            if (q.cnt != '0) begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign top_val = (q.cnt != '0) ? q.stk[0] : '0;
endmodule

// File: rtl/ack_format.sv
module ack_format
    import intack_pkg::*;
(
    input  logic [BASE_W-1:0] base,
    input  logic [VEC_W-1:0]  vec,
    input  logic              wide,
    output logic [WORD_W-1:0] word
);
    localparam int PAD_N = WORD_W - BASE_W - VEC_W;

    always_comb begin
        if (wide) begin
            word = {base[BASE_W-1:1], vec, {(PAD_N + 1){1'b0}}};
        end else begin
            word = {base, vec, {PAD_N{1'b0}}};
        end
    end
endmodule

// File: rtl/intack_unit.sv
module intack_unit
    import intack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vec,
    input  logic [PRI_W-1:0]  req_pri,
    input  logic              hw_mode,
    input  logic              wide_entry,
    input  logic              hw_ack,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [PRI_W-1:0]  cur_pri
);
    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [VEC_W-1:0]  vec;
        pri_t              pend;
        pri_t              cur;
    } state_t;

    state_t d, q;

    logic  ack_rd, ack_wr, eoi_wr;
    logic  do_push, do_pop;
    pri_t  lifo_top;
    logic [WORD_W-1:0] ack_word;
    logic  wdata_unused;

    assign ack_rd  = bus_sel && !bus_wr && (bus_addr == ACK_OFS);
    assign ack_wr  = bus_sel &&  bus_wr && (bus_addr == ACK_OFS);
    assign eoi_wr  = bus_sel &&  bus_wr && (bus_addr == EOI_OFS);
    assign do_push = hw_mode ? hw_ack : ack_rd;
    assign do_pop  = eoi_wr && !hw_mode;
    assign wdata_unused = ^bus_wdata[WORD_W-BASE_W-1:0];

    priority_lifo #(.DEPTH(DEPTH), .W(PRI_W)) u_lifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_push),
        .pop      (do_pop),
        .push_val (q.cur),
        .top_val  (lifo_top)
    );

    ack_format u_fmt (
        .base (q.base),
        .vec  (q.vec),
        .wide (wide_entry),
        .word (ack_word)
    );

    always_comb begin
        d = q;
        if (req_valid) begin
            d.vec  = req_vec;
            d.pend = req_pri;
        end
        if (ack_wr) begin
            d.base = bus_wdata[WORD_W-1 -: BASE_W];
        end
        if (do_push) begin
            d.cur = q.pend;
        end else if (do_pop) begin
            d.cur = lifo_top;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata = ack_rd ? ack_word : '0;
    assign cur_pri   = q.cur;
endmodule

// File: rtl/intack_checker.sv
module intack_checker
    import intack_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hw_mode,
    input logic              wide_entry,
    input logic              hw_ack,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [PRI_W-1:0]  cur_pri,
    input logic [PRI_W-1:0]  pend,
    input logic [PRI_W-1:0]  top
);
    logic rd_ack, rd_other, wr_eoi;
    assign rd_ack   = bus_sel && !bus_wr && bus_addr == ACK_OFS;
    assign rd_other = bus_sel && !bus_wr && bus_addr != ACK_OFS;
    assign wr_eoi   = bus_sel &&  bus_wr && bus_addr == EOI_OFS;

    AST_NORMAL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && !wide_entry |-> bus_rdata[1:0] == 2'b00); // R3
    AST_WIDE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && wide_entry |-> bus_rdata[2:0] == 3'b000); // R4
    AST_SW_ACK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && !hw_mode |=> cur_pri == $past(pend)); // R5
    AST_HW_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && hw_mode && !hw_ack |=> $stable(cur_pri)); // R6
    AST_SW_EOI_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_eoi && !hw_mode |=> cur_pri == $past(top)); // R7
    AST_HW_EOI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_eoi && hw_mode && !hw_ack |=> $stable(cur_pri)); // R8
    AST_OTHER_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_other |-> bus_rdata == '0); // R9
endmodule

bind intack_unit intack_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_mode    (hw_mode),
    .wide_entry (wide_entry),
    .hw_ack     (hw_ack),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .cur_pri    (cur_pri),
    .pend       (q.pend),
    .top        (lifo_top)
);

// File: tb/intack_unit_test.sv
module intack_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [8:0]  req_vec = '0;
    logic [3:0]  req_pri = '0;
    logic        hw_mode = 1'b0;
    logic        wide_entry = 1'b0;
    logic        hw_ack = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  cur_pri;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    intack_unit uut (.*);

    typedef struct packed {
        logic        wide;
        logic [20:0] base;
        logic [8:0]  vec;
        logic [31:0] exp;
    } vrow_t;

    localparam vrow_t TBL [0:5] = '{
        '{1'b0, 21'h000000, 9'h001, 32'h00000004},
        '{1'b0, 21'h1FFFFF, 9'h1FF, 32'hFFFFFFFC},
        '{1'b0, 21'h00A5A5, 9'h0C3, 32'h052D2B0C},
        '{1'b1, 21'h1FFFFF, 9'h1FF, 32'hFFFFFFF8},
        '{1'b1, 21'h00A5A5, 9'h0C3, 32'h052D2618},
        '{1'b1, 21'h000001, 9'h100, 32'h00000800}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_req(input logic [8:0] v, input logic [3:0] p);
        @(negedge clk);
        req_valid = 1'b1; req_vec = v; req_pri = p;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 data = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        hw_ack = 1'b1;
        @(negedge clk);
        hw_ack = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        logic [3:0]  model [0:15];
        int          mcnt;
        do_reset();

        // R1: reset state
        hw_mode = 1'b1;
        check("R1 cur_pri after reset", {28'h0, cur_pri}, 32'h0);
        bus_read(8'h14, rd);
        check("R1 ack word after reset", rd, 32'h0);

        // R2: vector holds while request is low
        set_req(9'h055, 4'h2);
        @(negedge clk);
        req_vec = 9'h0AA;
        bus_read(8'h14, rd);
        check("R2 vector held", rd, 32'h00000154);

        // R3/R4: table of acknowledge word layouts (hardware mode, so reads push nothing)
        foreach (TBL[i]) begin
            bus_write(8'h14, {TBL[i].base, 11'h0});
            set_req(TBL[i].vec, 4'h1);
            wide_entry = TBL[i].wide;
            bus_read(8'h14, rd);
            check(TBL[i].wide ? "R4 wide layout" : "R3 normal layout", rd, TBL[i].exp);
        end
        wide_entry = 1'b0;

        // R5, R7, R11, R9: software vector mode
        do_reset();
        hw_mode = 1'b0;
        set_req(9'h003, 4'h5);
        bus_read(8'h14, rd);
        check("R5 ack raises priority", {28'h0, cur_pri}, 32'h5);
        set_req(9'h004, 4'h9);
        bus_read(8'h14, rd);
        check("R5 nested ack", {28'h0, cur_pri}, 32'h9);
        bus_write(8'h18, 32'h0);
        check("R7 eoi pop zero data", {28'h0, cur_pri}, 32'h5);
        bus_write(8'h18, 32'hFFFFFFFF);
        check("R7 eoi pop ones data", {28'h0, cur_pri}, 32'h0);
        bus_write(8'h18, 32'h12345678);
        check("R11 pop empty", {28'h0, cur_pri}, 32'h0);
        bus_read(8'h18, rd);
        check("R9 eoi reads zero", rd, 32'h0);
        bus_read(8'h20, rd);
        check("R9 other offset reads zero", rd, 32'h0);

        // R6, R8: hardware vector mode
        hw_mode = 1'b1;
        set_req(9'h010, 4'h7);
        bus_read(8'h14, rd);
        check("R6 hw read no push", {28'h0, cur_pri}, 32'h0);
        pulse_ack();
        check("R6 hw ack pushes", {28'h0, cur_pri}, 32'h7);
        bus_write(8'h18, 32'h0);
        check("R8 hw eoi no pop", {28'h0, cur_pri}, 32'h7);
        hw_mode = 1'b0;
        set_req(9'h011, 4'h3);
        pulse_ack();
        check("R6 hw ack ignored in sw mode", {28'h0, cur_pri}, 32'h7);
        bus_write(8'h18, 32'h0);
        check("R7 pop after hw push", {28'h0, cur_pri}, 32'h0);

        // R10, R11: overfill the stack (bench model of a 15-deep stack)
        do_reset();
        mcnt = 0;
        for (int k = 1; k <= 17; k++) begin
            logic [3:0] p;
            p = 4'((k % 15) + 1);
            if (mcnt == 15) begin
                for (int j = 0; j < 14; j++) model[j] = model[j+1];
                model[14] = cur_pri;
            end else begin
                model[mcnt] = cur_pri;
                mcnt++;
            end
            set_req(9'(k), p);
            bus_read(8'h14, rd);
            check("R10 fill priority", {28'h0, cur_pri}, {28'h0, p});
        end
        for (int j = 0; j < 16; j++) begin
            logic [3:0] e;
            if (mcnt > 0) begin
                mcnt--;
                e = model[mcnt];
            end else begin
                e = 4'h0;
            end
            bus_write(8'h18, 32'h0);
            check(j == 15 ? "R11 pop past dropped entries" : "R10 pop order", {28'h0, cur_pri}, {28'h0, e});
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule